// File: doc/BRIEF.md
# Latching Relay Bank Pulse Sequencer

This block drives the coils of a matrix of latching relays. The matrix is organised as banks of relays, 16 banks of 16 relays by default. The host writes commands through a simple strobe port. Each command names one bank, carries a relay pattern with one bit per relay, and carries a direction flag that selects close or open. Each command lands in a small command queue and is acknowledged at once, so the host never waits for a coil to move.

A sequencer empties the queue in the order the commands were written. For each entry it holds the bank select and the relay pattern steady, and raises exactly one coil enable for a fixed pulse width. The close enable is used for close commands and the open enable for open commands. A guard gap separates consecutive pulses. When the queue has been fully drained, the host gets a single interrupt. The interrupt stays raised until the host clears it.

Latching relays keep their state across a reset. For that reason the block starts every reset with a sweep: it gives each bank, in ascending order, one open pulse with every relay bit set. The sweep raises no interrupt.

Top module: `relay_bank_seq`

## Requirements
- R1: A write strobe while the queue is not full stores the command, and `wr_ack` is high for exactly the following cycle. `wr_ack` is never high unless the strobe was high one cycle earlier.
- R2: A write strobe while the queue is full is refused. `wr_ack` stays low, `overflow` goes high in the following cycle, and `overflow` stays high until reset. A refused command is never executed.
- R3: Accepted commands are executed in write order, one pulse each. During a pulse, `coil_bank` equals the command's bank, `coil_data` equals its pattern, and only the enable selected by the flag is high: `wr_close` = 1 selects `coil_close_en`, and `wr_close` = 0 selects `coil_open_en`.
- R4: Every pulse keeps its enable high for exactly PULSE_CYCLES = (CLK_HZ/1000)*PULSE_MS consecutive cycles.
- R5: `coil_bank` and `coil_data` do not change while an enable is high. `coil_open_en` and `coil_close_en` are never high together.
- R6: Between two pulses, both enables are low for at least GAP_CYCLES+1 cycles.
- R7: After reset the block pulses banks 0 to NUM_BANKS-1 in ascending order. Each of these pulses uses the open enable with all pattern bits set to 1. After the sweep, `busy` falls and `irq` stays low.
- R8: `irq` rises once, in the cycle after the last queued command's guard gap, when the queue has run empty. It does not rise for each command. At its rise every accepted command has completed its pulse.
- R9: `irq` stays high until a cycle with `irq_clr` high, after which it is low. Commands written while `irq` is high do not clear it.
- R10: While reset is held, both enables, `irq`, `wr_ack` and `overflow` are low and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Command write strobe |
| wr_bank | input | BANK_SEL_W | Bank address of the command |
| wr_pattern | input | BANK_RELAYS | One bit per relay of the bank |
| wr_close | input | 1 | 1 = close the selected relays, 0 = open them |
| wr_ack | output | 1 | One-cycle acknowledge of a stored command |
| irq_clr | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Command list finished |
| busy | output | 1 | Sweep or command execution in progress |
| overflow | output | 1 | Sticky flag: a write was refused |
| coil_bank | output | BANK_SEL_W | Bank select of the current pulse |
| coil_data | output | BANK_RELAYS | Relay pattern of the current pulse |
| coil_open_en | output | 1 | Open-coil pulse enable |
| coil_close_en | output | 1 | Close-coil pulse enable |

## Verification
The reset sweep checks ordering against a fixed all-ones open pattern. Directed lists then use the extreme banks 0 and 15, the empty pattern, the full pattern and both directions. These lists separate a swapped enable or a misrouted bank field from a correct one. A burst of back-to-back writes fills the queue while it drains, which forces refusals in between acceptances; it shows that refused commands are dropped and that order is kept around them. Seeded random lists of one to four commands check that only one interrupt is raised per list, whatever the list length. A command written while the interrupt is pending checks that the interrupt is held.

// File: rtl/rbs_pkg.sv
`timescale 1ns/1ps
package rbs_pkg;

   typedef enum logic [2:0] {
      RBS_IDLE  = 3'd0,
      RBS_FETCH = 3'd1,
      RBS_PULSE = 3'd2,
      RBS_GAP   = 3'd3,
      RBS_DONE  = 3'd4
   } rbs_state_e;

   function automatic int rbs_width(input int value);
      return (value > 1) ? $clog2(value) : 1;
   endfunction

endpackage

// File: rtl/rbs_write_port.sv
`timescale 1ns/1ps
module rbs_write_port (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic fifo_full,
   output logic fifo_push,
   output logic wr_ack,
   output logic overflow
);

   assign fifo_push = wr_stb & ~fifo_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ack   <= 1'b0;
         overflow <= 1'b0;
      end else begin
         wr_ack <= fifo_push;
         if (wr_stb && fifo_full)
            overflow <= 1'b1;
      end
   end

endmodule

// File: rtl/rbs_cmd_fifo.sv
`timescale 1ns/1ps
module rbs_cmd_fifo #(
   parameter int WIDTH = 21,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);

   localparam int PTR_W = rbs_pkg::rbs_width(DEPTH);
   localparam int CNT_W = rbs_pkg::rbs_width(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rbs_cmd_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic             valid;
      logic [WIDTH-1:0] slot;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid <= 1'b0;
         end else if (push) begin
            valid <= 1'b1;
         end else if (pop) begin
            valid <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (push)
            slot <= push_data;
      end

      assign head  = slot;
      assign full  = valid;
      assign empty = ~valid;
   end else begin : g_ring
      logic [WIDTH-1:0] mem [DEPTH];
      logic [PTR_W-1:0] wr_ptr;
      logic [PTR_W-1:0] rd_ptr;
      logic [CNT_W-1:0] count;
      logic             do_pop;

      assign do_pop = pop && (count != '0);

      function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
         return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
      endfunction

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
         end else begin
            if (push)
               wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)
               rd_ptr <= next_ptr(rd_ptr);
            if (push && !do_pop)
               count <= count + CNT_W'(1);
            else if (do_pop && !push)
               count <= count - CNT_W'(1);
         end
      end

      always_ff @(posedge clk) begin
         if (push)
            mem[wr_ptr] <= push_data;
      end

      assign head  = mem[rd_ptr];
      assign full  = (count == CNT_W'(DEPTH));
      assign empty = (count == '0);
   end

endmodule

// File: rtl/rbs_pulse_timer.sv
`timescale 1ns/1ps
module rbs_pulse_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] length,
   output logic             expired
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= length - CNT_W'(1);
      end else if (remain != '0) begin
         remain <= remain - CNT_W'(1);
      end
   end

   assign expired = (remain == '0);

endmodule

// File: rtl/rbs_sequencer.sv
`timescale 1ns/1ps
module rbs_sequencer #(
   parameter int NUM_BANKS    = 16,
   parameter int BANK_RELAYS  = 16,
   parameter int PULSE_CYCLES = 4,
   parameter int GAP_CYCLES   = 1,
   parameter int CNT_W        = 8,
   parameter int BANK_SEL_W   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fifo_empty,
   input  logic [BANK_SEL_W-1:0]  head_bank,
   input  logic [BANK_RELAYS-1:0] head_pattern,
   input  logic                   head_close,
   output logic                   fifo_pop,
   input  logic                   timer_expired,
   output logic                   timer_load,
   output logic [CNT_W-1:0]       timer_length,
   input  logic                   irq_clr,
   output logic                   irq,
   output logic                   busy,
   output logic [BANK_SEL_W-1:0]  coil_bank,
   output logic [BANK_RELAYS-1:0] coil_data,
   output logic                   coil_open_en,
   output logic                   coil_close_en
);

   import rbs_pkg::*;

   localparam logic [BANK_SEL_W-1:0] LAST_BANK = BANK_SEL_W'(NUM_BANKS - 1);

   rbs_state_e            state;
   logic                  sweeping;
   logic [BANK_SEL_W-1:0] sweep_bank;
   logic                  pulse_end;
   logic                  gap_end;

   assign pulse_end    = (state == RBS_PULSE) && timer_expired;
   assign gap_end      = (state == RBS_GAP) && timer_expired;
   assign fifo_pop     = (state == RBS_FETCH) && !sweeping;
   assign timer_load   = (state == RBS_FETCH) || pulse_end;
   assign timer_length = (state == RBS_FETCH) ? CNT_W'(PULSE_CYCLES) : CNT_W'(GAP_CYCLES);
   assign busy         = (state != RBS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= RBS_FETCH;
         sweeping      <= 1'b1;
         sweep_bank    <= '0;
         coil_bank     <= '0;
         coil_data     <= '0;
         coil_open_en  <= 1'b0;
         coil_close_en <= 1'b0;
      end else begin
         unique case (state)
            RBS_IDLE: begin
               if (!fifo_empty)
                  state <= RBS_FETCH;
            end
            RBS_FETCH: begin
               if (sweeping) begin
                  coil_bank     <= sweep_bank;
                  coil_data     <= '1;
                  coil_open_en  <= 1'b1;
                  coil_close_en <= 1'b0;
               end else begin
                  coil_bank     <= head_bank;
                  coil_data     <= head_pattern;
                  coil_open_en  <= ~head_close;
                  coil_close_en <= head_close;
               end
               state <= RBS_PULSE;
            end
            RBS_PULSE: begin
               if (pulse_end) begin
                  coil_open_en  <= 1'b0;
                  coil_close_en <= 1'b0;
                  state         <= RBS_GAP;
               end
            end
            RBS_GAP: begin
               if (gap_end) begin
                  if (sweeping) begin
                     if (sweep_bank == LAST_BANK) begin
                        sweeping <= 1'b0;
                        state    <= fifo_empty ? RBS_IDLE : RBS_FETCH;
                     end else begin
                        sweep_bank <= sweep_bank + BANK_SEL_W'(1);
                        state      <= RBS_FETCH;
                     end
                  end else begin
                     state <= fifo_empty ? RBS_DONE : RBS_FETCH;
                  end
               end
            end
            RBS_DONE: begin
               state <= RBS_IDLE;
            end
            default: state <= RBS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (state == RBS_DONE)
         irq <= 1'b1;
      else if (irq_clr)
         irq <= 1'b0;
   end

endmodule

// File: rtl/relay_bank_seq.sv
`timescale 1ns/1ps
module relay_bank_seq #(
   parameter int NUM_BANKS   = 16,
   parameter int BANK_RELAYS = 16,
   parameter int FIFO_DEPTH  = 4,
   parameter int CLK_HZ      = 200_000_000,
   parameter int PULSE_MS    = 7,
   parameter int GAP_CYCLES  = 1,
   localparam int BANK_SEL_W = rbs_pkg::rbs_width(NUM_BANKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_stb,
   input  logic [BANK_SEL_W-1:0]  wr_bank,
   input  logic [BANK_RELAYS-1:0] wr_pattern,
   input  logic                   wr_close,
   output logic                   wr_ack,
   input  logic                   irq_clr,
   output logic                   irq,
   output logic                   busy,
   output logic                   overflow,
   output logic [BANK_SEL_W-1:0]  coil_bank,
   output logic [BANK_RELAYS-1:0] coil_data,
   output logic                   coil_open_en,
   output logic                   coil_close_en
);

   localparam int PULSE_CYCLES = (CLK_HZ / 1000) * PULSE_MS;
   localparam int LONGEST      = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES;
   localparam int CNT_W        = rbs_pkg::rbs_width(LONGEST + 1);
   localparam int CMD_W        = 1 + BANK_SEL_W + BANK_RELAYS;

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("relay_bank_seq: NUM_BANKS must be at least 2");
   end
   if (BANK_RELAYS < 1) begin : g_bad_relays
      $error("relay_bank_seq: BANK_RELAYS must be at least 1");
   end
   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("relay_bank_seq: pulse must last at least one cycle");
   end
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("relay_bank_seq: GAP_CYCLES must be at least 1");
   end

   logic                   fifo_push;
   logic                   fifo_pop;
   logic                   fifo_full;
   logic                   fifo_empty;
   logic [CMD_W-1:0]       fifo_head;
   logic                   timer_load;
   logic [CNT_W-1:0]       timer_length;
   logic                   timer_expired;
   logic                   head_close;
   logic [BANK_SEL_W-1:0]  head_bank;
   logic [BANK_RELAYS-1:0] head_pattern;

   assign {head_close, head_bank, head_pattern} = fifo_head;

   rbs_write_port i_write_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .fifo_full (fifo_full),
      .fifo_push (fifo_push),
      .wr_ack    (wr_ack),
      .overflow  (overflow)
   );

   rbs_cmd_fifo #(
      .WIDTH (CMD_W),
      .DEPTH (FIFO_DEPTH)
   ) i_cmd_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push),
      .push_data ({wr_close, wr_bank, wr_pattern}),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   rbs_pulse_timer #(
      .CNT_W (CNT_W)
   ) i_pulse_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (timer_load),
      .length  (timer_length),
      .expired (timer_expired)
   );

   rbs_sequencer #(
      .NUM_BANKS    (NUM_BANKS),
      .BANK_RELAYS  (BANK_RELAYS),
      .PULSE_CYCLES (PULSE_CYCLES),
      .GAP_CYCLES   (GAP_CYCLES),
      .CNT_W        (CNT_W),
      .BANK_SEL_W   (BANK_SEL_W)
   ) i_sequencer (
      .clk           (clk),
      .rst_n         (rst_n),
      .fifo_empty    (fifo_empty),
      .head_bank     (head_bank),
      .head_pattern  (head_pattern),
      .head_close    (head_close),
      .fifo_pop      (fifo_pop),
      .timer_expired (timer_expired),
      .timer_load    (timer_load),
      .timer_length  (timer_length),
      .irq_clr       (irq_clr),
      .irq           (irq),
      .busy          (busy),
      .coil_bank     (coil_bank),
      .coil_data     (coil_data),
      .coil_open_en  (coil_open_en),
      .coil_close_en (coil_close_en)
   );

endmodule

// File: rtl/rbs_checker.sv
`timescale 1ns/1ps
module rbs_checker #(
   parameter int PULSE_CYCLES = 4,
   parameter int BANK_SEL_W   = 4,
   parameter int BANK_RELAYS  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_stb,
   input logic                   wr_ack,
   input logic                   overflow,
   input logic                   irq,
   input logic                   irq_clr,
   input logic [BANK_SEL_W-1:0]  coil_bank,
   input logic [BANK_RELAYS-1:0] coil_data,
   input logic                   coil_open_en,
   input logic                   coil_close_en
);

   logic en;
   int   hi_cnt;

   assign en = coil_open_en | coil_close_en;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_cnt <= 0;
      else
         hi_cnt <= en ? hi_cnt + 1 : 0;
   end

   assert_ack_follows_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |-> $past(wr_stb));

   assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overflow) |-> overflow);

   assert_width_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (hi_cnt < PULSE_CYCLES));

   assert_width_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(en)) |-> ($past(hi_cnt) == PULSE_CYCLES - 1));

   assert_one_coil_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(coil_open_en && coil_close_en));

   assert_hold_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> ($stable(coil_bank) && $stable(coil_data)));

   assert_guard_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(en)) |=> !en);

   assert_irq_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !en);

   assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && !$past(irq_clr)) |-> irq);

endmodule

bind relay_bank_seq rbs_checker #(
   .PULSE_CYCLES (PULSE_CYCLES),
   .BANK_SEL_W   (BANK_SEL_W),
   .BANK_RELAYS  (BANK_RELAYS)
) i_rbs_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_stb        (wr_stb),
   .wr_ack        (wr_ack),
   .overflow      (overflow),
   .irq           (irq),
   .irq_clr       (irq_clr),
   .coil_bank     (coil_bank),
   .coil_data     (coil_data),
   .coil_open_en  (coil_open_en),
   .coil_close_en (coil_close_en)
);

// File: tb/test_relay_bank_seq.sv
`timescale 1ns/1ps
module test_relay_bank_seq;

   localparam int NB     = 16;
   localparam int BR     = 16;
   localparam int FD     = 4;
   localparam int CLK_HZ = 4000;
   localparam int PMS    = 1;
   localparam int GAP    = 1;
   localparam int PCYC   = (CLK_HZ / 1000) * PMS;
   localparam int MAXE   = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [3:0]    wr_bank = '0;
   logic [BR-1:0] wr_pattern = '0;
   logic          wr_close = 1'b0;
   logic          wr_ack;
   logic          irq_clr = 1'b0;
   logic          irq;
   logic          busy;
   logic          overflow;
   logic [3:0]    coil_bank;
   logic [BR-1:0] coil_data;
   logic          coil_open_en;
   logic          coil_close_en;

   always #2.5 clk = ~clk;

   relay_bank_seq #(
      .NUM_BANKS   (NB),
      .BANK_RELAYS (BR),
      .FIFO_DEPTH  (FD),
      .CLK_HZ      (CLK_HZ),
      .PULSE_MS    (PMS),
      .GAP_CYCLES  (GAP)
   ) i_relay_bank_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_stb        (wr_stb),
      .wr_bank       (wr_bank),
      .wr_pattern    (wr_pattern),
      .wr_close      (wr_close),
      .wr_ack        (wr_ack),
      .irq_clr       (irq_clr),
      .irq           (irq),
      .busy          (busy),
      .overflow      (overflow),
      .coil_bank     (coil_bank),
      .coil_data     (coil_data),
      .coil_open_en  (coil_open_en),
      .coil_close_en (coil_close_en)
   );

   int checks = 0;
   int failures = 0;
   int exp_bank [MAXE];
   int exp_data [MAXE];
   int exp_close [MAXE];
   int n_exp = 0;
   int n_start = 0;
   int n_end = 0;
   int irq_rises = 0;
   int cycles = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   function automatic void push_exp(input int b, input int d, input int c);
      exp_bank[n_exp]  = b;
      exp_data[n_exp]  = d;
      exp_close[n_exp] = c;
      n_exp++;
   endfunction

   // pulse monitor
   bit  prev_en = 1'b0;
   bit  prev_irq = 1'b0;
   int  width = 0;
   int  low_run = 100;
   int  cur_bank = 0;
   int  cur_data = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         automatic bit en = coil_open_en | coil_close_en;
         if (coil_open_en && coil_close_en)
            chk(1'b0, "R5", "both enables high", 1, 0);
         if (en && !prev_en) begin
            automatic string rq = (n_start < NB) ? "R7" : "R3";
            chk(low_run >= GAP + 1, "R6", "guard gap cycles", low_run, GAP + 1);
            if (n_start >= n_exp) begin
               chk(1'b0, "R2", "unexpected pulse index", n_start, n_exp);
            end else begin
               chk(int'(coil_bank) == exp_bank[n_start], rq, "pulse bank",
                   int'(coil_bank), exp_bank[n_start]);
               chk(int'(coil_data) == exp_data[n_start], rq, "pulse pattern",
                   int'(coil_data), exp_data[n_start]);
               chk(int'(coil_close_en) == exp_close[n_start], rq, "close enable",
                   int'(coil_close_en), exp_close[n_start]);
            end
            cur_bank = int'(coil_bank);
            cur_data = int'(coil_data);
            width = 1;
            n_start++;
         end else if (en) begin
            width++;
            if (int'(coil_bank) != cur_bank || int'(coil_data) != cur_data)
               chk(1'b0, "R5", "select changed in pulse", int'(coil_data), cur_data);
         end
         if (!en && prev_en) begin
            chk(width == PCYC, "R4", "pulse width", width, PCYC);
            n_end++;
            low_run = 0;
         end
         if (!en) low_run++;
         if (irq && !prev_irq) begin
            irq_rises++;
            chk(n_end == n_exp, "R8", "pulses done at irq rise", n_end, n_exp);
         end
         prev_en  = en;
         prev_irq = irq;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 60000 && !done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 60000);
         summary();
         $finish;
      end
   end

   task automatic do_write(input int b, input int d, input int c);
      @(negedge clk);
      wr_stb     = 1'b1;
      wr_bank    = 4'(b);
      wr_pattern = BR'(d);
      wr_close   = c[0];
      @(negedge clk);
      wr_stb = 1'b0;
      chk(wr_ack == 1'b1, "R1", "write acknowledge", int'(wr_ack), 1);
      if (wr_ack) push_exp(b, d, c);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(n_end == n_exp && !busy));
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_irq();
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(irq == 1'b0, "R9", "irq after clear", int'(irq), 0);
   endtask

   initial begin
      int seed_dummy;
      int rise0;
      int acc;
      int rej;
      seed_dummy = $urandom(32'h5EED_0042);
      for (int i = 0; i < NB; i++) push_exp(i, 32'hFFFF, 0);

      repeat (3) @(negedge clk);
      chk(!coil_open_en && !coil_close_en, "R10", "enables in reset",
          int'({coil_open_en, coil_close_en}), 0);
      chk(irq == 1'b0 && wr_ack == 1'b0, "R10", "irq/ack in reset",
          int'({irq, wr_ack}), 0);
      chk(overflow == 1'b0, "R10", "overflow in reset", int'(overflow), 0);
      chk(busy == 1'b1, "R10", "busy in reset", int'(busy), 1);
      rst_n = 1'b1;

      // R7: sweep then quiet
      wait_idle();
      chk(n_end == NB, "R7", "sweep pulse count", n_end, NB);
      chk(busy == 1'b0, "R7", "busy after sweep", int'(busy), 0);
      chk(irq == 1'b0 && irq_rises == 0, "R7", "no irq after sweep", irq_rises, 0);

      // directed list: extremes of bank, pattern and direction
      rise0 = irq_rises;
      do_write(15, 32'h0000, 1);
      do_write(0, 32'hFFFF, 1);
      do_write(7, 32'hA5C3, 0);
      wait_idle();
      chk(irq_rises == rise0 + 1, "R8", "one irq per list", irq_rises, rise0 + 1);
      chk(irq == 1'b1, "R8", "irq pending", int'(irq), 1);

      // R9: new command while pending does not clear the interrupt
      do_write(3, 32'h0180, 0);
      chk(irq == 1'b1, "R9", "irq kept on write", int'(irq), 1);
      wait_idle();
      chk(irq == 1'b1 && irq_rises == rise0 + 1, "R9", "irq still held",
          irq_rises, rise0 + 1);
      clear_irq();
      repeat (3) @(negedge clk);
      chk(irq == 1'b0, "R9", "irq stays cleared", int'(irq), 0);

      // R2: back-to-back burst overflows the queue
      chk(overflow == 1'b0, "R2", "overflow before burst", int'(overflow), 0);
      rise0 = irq_rises;
      acc = 0;
      rej = 0;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (i > 0) begin
            if (wr_ack) begin
               push_exp(i + 4, 32'h1111 * i, (i - 1) % 2);
               acc++;
            end else begin
               rej++;
            end
         end
         if (i < 8) begin
            wr_stb     = 1'b1;
            wr_bank    = 4'(i + 5);
            wr_pattern = BR'(32'h1111 * (i + 1));
            wr_close   = i[0];
         end else begin
            wr_stb = 1'b0;
         end
      end
      chk(overflow == 1'b1, "R2", "overflow after burst", int'(overflow), 1);
      chk(acc >= FD, "R2", "accepted in burst", acc, FD);
      chk(rej >= 1, "R2", "refused in burst", rej, 1);
      wait_idle();
      chk(irq_rises == rise0 + 1, "R8", "one irq after burst", irq_rises, rise0 + 1);
      clear_irq();

      // seeded random lists
      for (int l = 0; l < 25; l++) begin
         int len;
         len  = 1 + int'($urandom % FD);
         rise0 = irq_rises;
         for (int k = 0; k < len; k++)
            do_write(int'($urandom % NB), int'($urandom % 65536), int'($urandom % 2));
         wait_idle();
         chk(irq_rises == rise0 + 1, "R8", "one irq per random list",
             irq_rises, rise0 + 1);
         repeat (int'($urandom % 4)) @(negedge clk);
         clear_irq();
      end

      chk(overflow == 1'b1, "R2", "overflow sticky at end", int'(overflow), 1);
      chk(n_start == n_exp, "R3", "total pulses", n_start, n_exp);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule